// File: doc/BRIEF.md
# Legacy System Control Port Registers

This block sits on a byte-wide I/O bus and answers four legacy system control ports. The index port holds a master NMI mask and a 7-bit index that is forwarded to an external clock/CMOS block. The fast-gate port holds an alternate address-line-20 gate bit, which is ORed with an external gate pin to form the A20 mask output. It also holds an init bit: setting it produces a timed, active-low processor init pulse. The control port gates timer channel 2, routes that channel's output to the speaker, and masks and clears an error-driven NMI source.

Reads are combinational. `io_rdata` is valid in the same cycle as `io_rd` and `io_addr`. Writes take effect at the clock edge that samples `io_wr`. The init pulse is sequenced by a two-state machine. In state INIT_IDLE `init_n` is high. The transition IDLE_TO_PULSE is taken when a write to the fast-gate port moves the init bit from 0 to 1. In state INIT_PULSE `init_n` is low and a counter runs. The transition PULSE_TO_IDLE is taken once the counter has covered `PULSE_CYCLES` clocks. A trigger that arrives during INIT_PULSE is ignored.

Top module: `sysctl_ports`

## Requirements
- R1: After reset, the index port reads 80h (mask set, index 0), the fast-gate port and the control port read 00h, `rtc_index` is 0, `init_n` is 1 and `nmi_out` is 0.
- R2: A write to the index port (70h) stores bit 7 as the NMI mask (1 = all NMIs blocked) and bits 6:0 as the index, which appears on `rtc_index` after the write edge.
- R3: A read of 70h returns the mask in bit 7. Bits 6:0 read as 0 unless `alt_access` is 1, in which case they return the stored index.
- R4: Port 74h is an alias of the same register. All eight bits are always readable there, and a write there updates the same register.
- R5: Port 92h stores bit 1 (alternate A20) and bit 0 (init). Bits 7:2 read as 0. `a20_mask` equals bit 1 OR `a20_gate_in`.
- R6: A write that moves 92h bit 0 from 0 to 1 drives `init_n` low from the cycle after the write for exactly `PULSE_CYCLES` (default 16) clocks.
- R7: Writing 1 to bit 0 while it is already 1 gives no pulse. A new 0-to-1 write during a running pulse does not stretch it. Bit 0 reads back as the last value written.
- R8: Port 61h bit 0 drives `tmr2_gate`. Bit 1 selects `spkr_out`: 0 forces it to 0, and 1 makes it follow `tmr2_out`.
- R9: While 61h bit 2 is 0, a high `err_src` sampled at a clock edge latches an error-pending flag, readable as 61h bit 7. While bit 2 is 1, the flag is cleared and reads 0, and `err_src` is ignored. 61h bits 6:3 read as 0.
- R10: `nmi_out` is 1 exactly when the error flag is pending, 61h bit 2 is 0 and the NMI mask is 0.
- R11: Reads of unmapped addresses, and all reads with `io_rd` low, return 00h. Writes to unmapped addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W | I/O port address |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 8 | Read data (combinational) |
| alt_access | input | 1 | Alternate-access mode, exposes the index on 70h reads |
| a20_gate_in | input | 1 | External A20 gate |
| err_src | input | 1 | Error event for the error NMI source |
| tmr2_out | input | 1 | Timer channel 2 output |
| rtc_index | output | 7 | Index forwarded to the clock/CMOS block |
| a20_mask | output | 1 | A20 mask to the processor |
| init_n | output | 1 | Active-low processor init |
| tmr2_gate | output | 1 | Timer channel 2 gate |
| spkr_out | output | 1 | Speaker output |
| nmi_out | output | 1 | NMI request |

## Verification
The assertions are checked on every cycle. They cover four things: the A20 mask follows its external pin, the speaker never sounds without the timer output, and `rtc_index` moves only after an index-port or alias write. Each falling edge of `init_n` follows a triggering write, and each pulse lasts exactly `PULSE_CYCLES`. They also check that `nmi_out` stays low while the mask or the error disable is set. The bench scenarios are needed for the cases that depend on the history of writes: the write-only masking of the index under normal and alternate access, reserved bits reading zero, the absence of a pulse on a repeated 1, no stretching on a mid-pulse retrigger, and the error flag persisting under the mask and being cleared by the disable bit.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
    typedef enum logic {
        INIT_IDLE  = 1'b0,
        INIT_PULSE = 1'b1
    } init_state_t;
endpackage

// File: rtl/sysctl_idx_reg.sv
module sysctl_idx_reg #(
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W:0]   wdata,
    output logic             nmi_mask,
    output logic [IDX_W-1:0] rtc_index
);
    // R1 R2: mask resets set, index resets to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_mask  <= 1'b1;
            rtc_index <= '0;
        end else if (wr_en) begin
            nmi_mask  <= wdata[IDX_W];
            rtc_index <= wdata[IDX_W-1:0];
        end
    end
endmodule

// File: rtl/sysctl_init_fsm.sv
module sysctl_init_fsm
    import sysctl_pkg::*;
#(
    parameter int PULSE_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wdata,
    output logic       alt_a20,
    output logic       init_bit,
    output logic       init_n
);
    localparam int CNT_W = (PULSE_CYCLES > 2) ? $clog2(PULSE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSE_CYCLES - 1);

    init_state_t     state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             trigger;

    // R6 R7: only a 0-to-1 change of the stored bit can start a pulse
    assign trigger = wr_en && wdata[0] && !init_bit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alt_a20  <= 1'b0;
            init_bit <= 1'b0;
        end else if (wr_en) begin
            alt_a20  <= wdata[1];
            init_bit <= wdata[0];
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            INIT_IDLE:  if (trigger)       state_d = INIT_PULSE; // IDLE_TO_PULSE
            INIT_PULSE: if (cnt_q == LAST) state_d = INIT_IDLE;  // PULSE_TO_IDLE
            default:                       state_d = INIT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= INIT_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_q == INIT_PULSE) ? cnt_q + 1'b1 : '0;
        end
    end

    always_comb begin
        init_n = (state_q != INIT_PULSE);
    end
endmodule

// File: rtl/sysctl_misc_ctl.sv
module sysctl_misc_ctl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] wdata,
    input  logic       err_src,
    input  logic       tmr2_out,
    output logic       tmr2_gate,
    output logic       spkr_en,
    output logic       err_dis,
    output logic       err_pend,
    output logic       spkr_out
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr2_gate <= 1'b0;
            spkr_en   <= 1'b0;
            err_dis   <= 1'b0;
        end else if (wr_en) begin
            tmr2_gate <= wdata[0];
            spkr_en   <= wdata[1];
            err_dis   <= wdata[2];
        end
    end

    // R9: disable clears the latch and blocks new events
    always_ff @(posedge clk) begin
        if (!rst_n)       pend_q <= 1'b0;
        else if (err_dis) pend_q <= 1'b0;
        else if (err_src) pend_q <= 1'b1;
    end

    assign err_pend = pend_q && !err_dis;
    // R8
    assign spkr_out = spkr_en && tmr2_out;
endmodule

// File: rtl/sysctl_ports.sv
module sysctl_ports #(
    parameter int             ADDR_W       = 8,
    parameter int             PULSE_CYCLES = 16,
    parameter logic [ADDR_W-1:0] PORT_IDX   = ADDR_W'('h70),
    parameter logic [ADDR_W-1:0] PORT_ALIAS = ADDR_W'('h74),
    parameter logic [ADDR_W-1:0] PORT_CTL   = ADDR_W'('h61),
    parameter logic [ADDR_W-1:0] PORT_A20   = ADDR_W'('h92)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [7:0]        io_wdata,
    input  logic              io_wr,
    input  logic              io_rd,
    output logic [7:0]        io_rdata,
    input  logic              alt_access,
    input  logic              a20_gate_in,
    input  logic              err_src,
    input  logic              tmr2_out,
    output logic [6:0]        rtc_index,
    output logic              a20_mask,
    output logic              init_n,
    output logic              tmr2_gate,
    output logic              spkr_out,
    output logic              nmi_out
);
    localparam int IDX_W = 7;

    logic hit_idx, hit_alias, hit_ctl, hit_a20;
    logic nmi_mask, alt_a20, init_bit, spkr_en, err_dis, err_pend;

    assign hit_idx   = (io_addr == PORT_IDX);
    assign hit_alias = (io_addr == PORT_ALIAS);
    assign hit_ctl   = (io_addr == PORT_CTL);
    assign hit_a20   = (io_addr == PORT_A20);

    sysctl_idx_reg #(.IDX_W(IDX_W)) u_idx (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (io_wr && (hit_idx || hit_alias)),
        .wdata     (io_wdata),
        .nmi_mask  (nmi_mask),
        .rtc_index (rtc_index)
    );

    sysctl_init_fsm #(.PULSE_CYCLES(PULSE_CYCLES)) u_init (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (io_wr && hit_a20),
        .wdata    (io_wdata[1:0]),
        .alt_a20  (alt_a20),
        .init_bit (init_bit),
        .init_n   (init_n)
    );

    sysctl_misc_ctl u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (io_wr && hit_ctl),
        .wdata     (io_wdata[2:0]),
        .err_src   (err_src),
        .tmr2_out  (tmr2_out),
        .tmr2_gate (tmr2_gate),
        .spkr_en   (spkr_en),
        .err_dis   (err_dis),
        .err_pend  (err_pend),
        .spkr_out  (spkr_out)
    );

    // R5
    assign a20_mask = alt_a20 || a20_gate_in;
    // R10
    assign nmi_out  = err_pend && !nmi_mask;

    // R3 R4 R11: combinational read mux
    always_comb begin
        io_rdata = 8'h00;
        if (io_rd) begin
            if (hit_idx)
                io_rdata = {nmi_mask, alt_access ? rtc_index : 7'd0};
            else if (hit_alias)
                io_rdata = {nmi_mask, rtc_index};
            else if (hit_ctl)
                io_rdata = {err_pend, 4'd0, err_dis, spkr_en, tmr2_gate};
            else if (hit_a20)
                io_rdata = {6'd0, alt_a20, init_bit};
        end
    end
endmodule

// File: rtl/sysctl_ports_chk.sv
module sysctl_ports_chk #(
    parameter int             ADDR_W       = 8,
    parameter int             PULSE_CYCLES = 16,
    parameter logic [ADDR_W-1:0] PORT_IDX   = ADDR_W'('h70),
    parameter logic [ADDR_W-1:0] PORT_ALIAS = ADDR_W'('h74),
    parameter logic [ADDR_W-1:0] PORT_A20   = ADDR_W'('h92)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] io_addr,
    input logic [7:0]        io_wdata,
    input logic              io_wr,
    input logic              a20_gate_in,
    input logic              tmr2_out,
    input logic [6:0]        rtc_index,
    input logic              a20_mask,
    input logic              init_n,
    input logic              spkr_out,
    input logic              nmi_out,
    input logic              nmi_mask,
    input logic              err_dis
);
    localparam int RUN_W = $clog2(PULSE_CYCLES + 2) + 1;
    logic [RUN_W-1:0] low_run;

    always_ff @(posedge clk) begin
        if (!rst_n)      low_run <= '0;
        else if (init_n) low_run <= '0;
        else             low_run <= low_run + 1'b1;
    end

    // R5
    a20_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        a20_gate_in |-> a20_mask);

    // R8
    spkr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spkr_out |-> tmr2_out);

    // R2
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && (io_addr == PORT_IDX || io_addr == PORT_ALIAS))
        |=> $stable(rtc_index));

    // R6
    init_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(init_n) |-> $past(io_wr && io_addr == PORT_A20 && io_wdata[0]));

    // R6 R7
    init_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_n) |-> (low_run == RUN_W'(PULSE_CYCLES)));

    // R10
    nmi_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_out |-> (!nmi_mask && !err_dis));
endmodule

bind sysctl_ports sysctl_ports_chk #(
    .ADDR_W       (ADDR_W),
    .PULSE_CYCLES (PULSE_CYCLES),
    .PORT_IDX     (PORT_IDX),
    .PORT_ALIAS   (PORT_ALIAS),
    .PORT_A20     (PORT_A20)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .io_addr     (io_addr),
    .io_wdata    (io_wdata),
    .io_wr       (io_wr),
    .a20_gate_in (a20_gate_in),
    .tmr2_out    (tmr2_out),
    .rtc_index   (rtc_index),
    .a20_mask    (a20_mask),
    .init_n      (init_n),
    .spkr_out    (spkr_out),
    .nmi_out     (nmi_out),
    .nmi_mask    (nmi_mask),
    .err_dis     (err_dis)
);

// File: tb/tb_sysctl_ports.sv
`timescale 1ns/1ps
module tb_sysctl_ports;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] io_addr = 8'h00;
    logic [7:0] io_wdata = 8'h00;
    logic       io_wr = 1'b0;
    logic       io_rd = 1'b0;
    logic [7:0] io_rdata;
    logic       alt_access = 1'b0;
    logic       a20_gate_in = 1'b0;
    logic       err_src = 1'b0;
    logic       tmr2_out = 1'b0;
    logic [6:0] rtc_index;
    logic       a20_mask, init_n, tmr2_gate, spkr_out, nmi_out;

    int checks = 0;
    int errors = 0;
    int low_total = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sysctl_ports dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata),
        .alt_access(alt_access), .a20_gate_in(a20_gate_in), .err_src(err_src),
        .tmr2_out(tmr2_out), .rtc_index(rtc_index), .a20_mask(a20_mask),
        .init_n(init_n), .tmr2_gate(tmr2_gate), .spkr_out(spkr_out),
        .nmi_out(nmi_out)
    );

    always @(negedge clk) if (rst_n && !init_n) low_total++;

    // {op(1=write,2=read), addr, wdata, alt, expected read}
    localparam int NV = 16;
    localparam logic [26:0] VEC [NV] = '{
        {2'd1, 8'h70, 8'h0A, 1'b0, 8'h00},  // R2 write index 0Ah, mask 0
        {2'd2, 8'h70, 8'h00, 1'b0, 8'h00},  // R3 index hidden
        {2'd2, 8'h70, 8'h00, 1'b1, 8'h0A},  // R3 alternate access
        {2'd2, 8'h74, 8'h00, 1'b0, 8'h0A},  // R4 alias read
        {2'd1, 8'h74, 8'h85, 1'b0, 8'h00},  // R4 alias write
        {2'd2, 8'h74, 8'h00, 1'b0, 8'h85},  // R4
        {2'd2, 8'h70, 8'h00, 1'b0, 8'h80},  // R3 mask visible
        {2'd1, 8'h61, 8'h03, 1'b0, 8'h00},  // R8
        {2'd2, 8'h61, 8'h00, 1'b0, 8'h03},  // R8
        {2'd1, 8'h61, 8'hFF, 1'b0, 8'h00},  // R9 reserved bits
        {2'd2, 8'h61, 8'h00, 1'b0, 8'h07},  // R9 bits 6:3 zero, flag 0
        {2'd1, 8'h92, 8'hFE, 1'b0, 8'h00},  // R5
        {2'd2, 8'h92, 8'h00, 1'b0, 8'h02},  // R5 bits 7:2 zero
        {2'd1, 8'h55, 8'hFF, 1'b0, 8'h00},  // R11 unmapped write
        {2'd2, 8'h55, 8'h00, 1'b0, 8'h00},  // R11 unmapped read
        {2'd2, 8'h74, 8'h00, 1'b0, 8'h85}   // R11 index untouched
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic io_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [7:0] a, input logic alt, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; alt_access = alt; io_rd = 1'b1;
        #1 d = io_rdata;
        io_rd = 1'b0; alt_access = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        io_read(8'h74, 1'b0, rd); chk("R1 74h", rd, 8'h80);
        io_read(8'h92, 1'b0, rd); chk("R1 92h", rd, 8'h00);
        io_read(8'h61, 1'b0, rd); chk("R1 61h", rd, 8'h00);
        chk("R1 rtc_index", {1'b0, rtc_index}, 8'h00);
        chk("R1 init_n/nmi_out", {6'd0, init_n, nmi_out}, 8'h02);
        // R11 read strobe low
        @(negedge clk); io_addr = 8'h74; #1 chk("R11 no strobe", io_rdata, 8'h00);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][26:25] == 2'd1) io_write(VEC[i][24:17], VEC[i][16:9]);
            else begin
                io_read(VEC[i][24:17], VEC[i][8], rd);
                chk($sformatf("vector %0d", i), rd, VEC[i][7:0]);
            end
        end
        chk("R2 rtc_index pin", {1'b0, rtc_index}, 8'h05);

        // R5 A20 mask
        io_write(8'h92, 8'h00);
        a20_gate_in = 1'b0; #1 chk("R5 both low", {7'd0, a20_mask}, 8'h00);
        a20_gate_in = 1'b1; #1 chk("R5 pin high", {7'd0, a20_mask}, 8'h01);
        a20_gate_in = 1'b0;
        io_write(8'h92, 8'h02); #1 chk("R5 bit high", {7'd0, a20_mask}, 8'h01);
        io_write(8'h92, 8'h00);

        // R8 speaker and gate
        io_write(8'h61, 8'h01); tmr2_out = 1'b1;
        #1 chk("R8 spkr off", {6'd0, tmr2_gate, spkr_out}, 8'h02);
        io_write(8'h61, 8'h02);
        #1 chk("R8 spkr follows 1", {6'd0, tmr2_gate, spkr_out}, 8'h01);
        tmr2_out = 1'b0; #1 chk("R8 spkr follows 0", {7'd0, spkr_out}, 8'h00);
        io_write(8'h61, 8'h00);

        // R6 single pulse
        #1 base = low_total;
        io_write(8'h92, 8'h01);
        #1 chk("R6 init low next cycle", {7'd0, init_n}, 8'h00);
        repeat (25) @(negedge clk);
        #1 chk("R6 pulse length", 8'(low_total - base), 8'd16);
        io_read(8'h92, 1'b0, rd); chk("R7 readback", rd, 8'h01);

        // R7 repeated 1 gives no pulse
        #1 base = low_total;
        io_write(8'h92, 8'h01);
        repeat (25) @(negedge clk);
        #1 chk("R7 no repeat pulse", 8'(low_total - base), 8'd0);

        // R7 retrigger during pulse does not stretch
        io_write(8'h92, 8'h00);
        #1 base = low_total;
        io_write(8'h92, 8'h01);
        repeat (4) @(negedge clk);
        io_write(8'h92, 8'h00);
        io_write(8'h92, 8'h01);
        repeat (30) @(negedge clk);
        #1 chk("R7 no stretch", 8'(low_total - base), 8'd16);

        // R9 R10 error NMI
        io_write(8'h70, 8'h00);
        io_write(8'h61, 8'h00);
        @(negedge clk); err_src = 1'b1;
        @(negedge clk); err_src = 1'b0;
        #1 chk("R10 nmi raised", {7'd0, nmi_out}, 8'h01);
        io_write(8'h70, 8'h80);
        #1 chk("R10 masked", {7'd0, nmi_out}, 8'h00);
        io_read(8'h61, 1'b0, rd); chk("R9 flag held", rd, 8'h80);
        io_write(8'h70, 8'h00);
        #1 chk("R10 unmasked", {7'd0, nmi_out}, 8'h01);
        io_write(8'h61, 8'h04);
        #1 chk("R9 disable blocks", {7'd0, nmi_out}, 8'h00);
        io_read(8'h61, 1'b0, rd); chk("R9 flag cleared", rd, 8'h04);
        @(negedge clk); err_src = 1'b1;
        @(negedge clk); err_src = 1'b0;
        io_write(8'h61, 8'h00);
        #1 chk("R9 ignored while disabled", {7'd0, nmi_out}, 8'h00);
        io_read(8'h61, 1'b0, rd); chk("R9 still clear", rd, 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule